// File: doc/BRIEF.md
# Nested Priority-Level Interrupt Controller

This block sits between up to eight interrupt sources and a processor. Each source has a fixed priority level from 0 to 7, supplied as a configuration input. The block tracks the level the processor is currently running at. Ordinary program code runs at level 0. The block offers an interrupt only when a latched request has a level strictly above that running level.

When the processor acknowledges, the block reports the winning source as a cause identifier. It raises the running level to that source's level and saves the previous level on a small internal stack. A higher-level request can therefore preempt a handler that is already running. Each return strobe restores the saved levels in reverse order.

Interrupts are offered only while the processor signals an instruction boundary. A stack overflow or underflow sets a sticky error flag.

Top module: `ipl_ctrl`

## Requirements
- R1: After reset the running level is 0, no request is latched, `int_out`, `vec_valid` and `stack_err` are 0.
- R2: `int_out` is high only while `at_boundary` is high and some latched request has a level strictly greater than `cur_level`; a request at or below `cur_level` stays latched but does not raise `int_out`.
- R3: Among eligible requests, the highest level wins; at equal level the lowest source index wins.
- R4: When `int_ack` is high while `int_out` is high (and `int_ret` is low), then on the next cycle `vec_valid` is high for that cycle and `vec_id` holds the winner's index. From that cycle on, `cur_level` equals the winner's level.
- R5: A request held high for even one cycle stays latched until that source is accepted by an acknowledge.
- R6: An accepted acknowledge clears only the winner's latched request; other latched requests remain.
- R7: `int_ret` with a non-empty stack restores `cur_level` to the most recently saved level (last in, first out).
- R8: `int_ret` with an empty stack sets `stack_err` and leaves `cur_level` unchanged.
- R9: An acknowledge that would push onto a full stack (STACK_DEPTH saved levels) is refused. `stack_err` is set, `cur_level` is unchanged, `vec_valid` stays low and the request stays latched.
- R10: `stack_err` stays high until reset.
- R11: When `int_ret` and `int_ack` are high in the same cycle, the return is performed and the acknowledge is ignored.
- R12: `int_ack` while `int_out` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Level-sensitive request, one bit per source |
| src_level | input | NUM_SRC*3 | Level of source i in bits [3i+2:3i] |
| at_boundary | input | 1 | Processor is at an instruction boundary |
| int_ack | input | 1 | Processor accepts the offered interrupt |
| int_ret | input | 1 | Return-from-handler strobe |
| int_out | output | 1 | Interrupt offered to the processor |
| vec_valid | output | 1 | One-cycle pulse after an accepted acknowledge |
| vec_id | output | log2(NUM_SRC) | Index of the accepted source |
| cur_level | output | 3 | Running processor priority level |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the block with eight sources and STACK_DEPTH set to 3. Strict level comparison limits nesting to seven saved levels, so the default depth of 8 can never overflow. With a depth of 3, a chain of requests at levels 1, 2, 3 and then 4 fills the stack, which makes the refused-acknowledge path of R9 reachable. The source levels are set to 7, 4, 4, 2, 1, 3, 0, 5. This gives a same-level tie and a level-0 source that can never be served.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W      = 3;
  localparam int NUM_LEVELS = 8;
  typedef logic [LVL_W-1:0] ipl_t;
endpackage

// File: rtl/ipl_req_latch.sv
module ipl_req_latch #(
  parameter int NUM_SRC = 8,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               clr_en,
  input  logic [ID_W-1:0]    clr_idx,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pending | req_in;
    if (clr_en) pend_nxt[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= pend_nxt;
  end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter
  import ipl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       pending,
  input  logic [NUM_SRC*LVL_W-1:0] src_level,
  input  ipl_t                     cur_level,
  output logic                     win_valid,
  output logic [ID_W-1:0]          win_id,
  output ipl_t                     win_level
);
  ipl_t lvl_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign lvl_arr[g] = src_level[g*LVL_W +: LVL_W];
  end

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_level = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (lvl_arr[i] > cur_level) &&
          (!win_valid || (lvl_arr[i] > win_level))) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_level = lvl_arr[i];
      end
    end
  end
endmodule

// File: rtl/ipl_level_stack.sv
module ipl_level_stack
  import ipl_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ADR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  ipl_t push_data,
  output ipl_t top,
  output logic full,
  output logic empty
);
  ipl_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [ADR_W-1:0] wr_idx;
  logic [ADR_W-1:0] rd_idx;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign wr_idx = ADR_W'(cnt);
  assign rd_idx = ADR_W'(cnt - 1'b1);
  assign top    = empty ? '0 : mem[rd_idx];

  always_comb begin
    cnt_nxt = cnt;
    if (push && !full)       cnt_nxt = cnt + 1'b1;
    else if (pop && !empty)  cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= push_data;
  end
endmodule

// File: rtl/ipl_ctrl.sv
module ipl_ctrl
  import ipl_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 8,
  localparam int ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC*LVL_W-1:0] src_level,
  input  logic                     at_boundary,
  input  logic                     int_ack,
  input  logic                     int_ret,
  output logic                     int_out,
  output logic                     vec_valid,
  output logic [ID_W-1:0]          vec_id,
  output ipl_t                     cur_level,
  output logic                     stack_err
);
  logic [NUM_SRC-1:0] pending;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;
  ipl_t               win_level;
  ipl_t               stk_top;
  logic               stk_full, stk_empty;
  logic               accept_try, do_push, do_pop, err_set;
  ipl_t               cur_nxt;
  logic               vv_nxt, err_nxt;
  logic [ID_W-1:0]    vid_nxt;

  ipl_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_in(irq_req),
    .clr_en(do_push), .clr_idx(win_id), .pending(pending)
  );

  ipl_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pending(pending), .src_level(src_level), .cur_level(cur_level),
    .win_valid(win_valid), .win_id(win_id), .win_level(win_level)
  );

  ipl_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .push_data(cur_level), .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  assign int_out    = win_valid && at_boundary;
  assign accept_try = int_ack && int_out && !int_ret;
  assign do_push    = accept_try && !stk_full;
  assign do_pop     = int_ret && !stk_empty;
  assign err_set    = (int_ret && stk_empty) || (accept_try && stk_full);

  always_comb begin
    cur_nxt = cur_level;
    if (do_pop)       cur_nxt = stk_top;
    else if (do_push) cur_nxt = win_level;
    vv_nxt  = do_push;
    vid_nxt = do_push ? win_id : vec_id;
    err_nxt = stack_err || err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_level <= '0;
      vec_valid <= 1'b0;
      vec_id    <= '0;
      stack_err <= 1'b0;
    end else begin
      cur_level <= cur_nxt;
      vec_valid <= vv_nxt;
      vec_id    <= vid_nxt;
      stack_err <= err_nxt;
    end
  end
endmodule

// File: rtl/ipl_ctrl_chk.sv
module ipl_ctrl_chk
  import ipl_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic at_boundary,
  input logic int_ack,
  input logic int_ret,
  input logic int_out,
  input logic vec_valid,
  input ipl_t cur_level,
  input logic stack_err
);
  AST_OFFER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> at_boundary); // R2
  AST_ACCEPT_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (cur_level > $past(cur_level))); // R4
  AST_LEVEL_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_ack && !int_ret) |=> $stable(cur_level)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err); // R10
  AST_RET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    int_ret |=> !vec_valid); // R11
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out) |=> !vec_valid); // R12
endmodule

bind ipl_ctrl ipl_ctrl_chk u_chk (.*);

// File: tb/ipl_ctrl_tb.sv
module ipl_ctrl_tb;
  localparam int NSRC  = 8;
  localparam int DEPTH = 3;
  localparam int LV [NSRC] = '{7, 4, 4, 2, 1, 3, 0, 5};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic [NSRC*3-1:0] src_level;
  logic            at_boundary = 1'b0, int_ack = 1'b0, int_ret = 1'b0;
  logic            int_out, vec_valid, stack_err;
  logic [2:0]      vec_id, cur_level;

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  ipl_ctrl #(.NUM_SRC(NSRC), .STACK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .src_level(src_level),
    .at_boundary(at_boundary), .int_ack(int_ack), .int_ret(int_ret),
    .int_out(int_out), .vec_valid(vec_valid), .vec_id(vec_id),
    .cur_level(cur_level), .stack_err(stack_err)
  );

  // behavioural reference
  bit m_pend [NSRC];
  int m_cur, m_vid;
  bit m_vv, m_err;
  int m_stk [$];

  function automatic void m_arb(output bit v, output int id, output int lv);
    v = 0; id = 0; lv = 0;
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i] && LV[i] > m_cur && (!v || LV[i] > lv)) begin
        v = 1; id = i; lv = LV[i];
      end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_cur = 0; m_vid = 0; m_vv = 0; m_err = 0;
      m_stk.delete();
    end else begin
      bit v; int id, lv; bit clr;
      m_arb(v, id, lv);
      clr = 0; m_vv = 0;
      if (int_ret) begin
        if (m_stk.size() == 0) m_err = 1;
        else m_cur = m_stk.pop_back();
      end else if (int_ack && v && at_boundary) begin
        if (m_stk.size() == DEPTH) m_err = 1;
        else begin
          m_stk.push_back(m_cur); m_cur = lv; clr = 1; m_vv = 1; m_vid = id;
        end
      end
      for (int i = 0; i < NSRC; i++)
        m_pend[i] = (m_pend[i] || irq_req[i]) && !(clr && i == id);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit v; int id, lv;
      m_arb(v, id, lv);
      check(int_out == (v && at_boundary), "R2 R3 R5 R12 int_out", int_out, v && at_boundary);
      check(cur_level == m_cur, "R4 R7 R9 R11 cur_level", cur_level, m_cur);
      check(vec_valid == m_vv, "R4 R6 R9 vec_valid", vec_valid, m_vv);
      if (m_vv) check(vec_id == m_vid, "R3 R4 vec_id", vec_id, m_vid);
      check(stack_err == m_err, "R8 R9 R10 stack_err", stack_err, m_err);
    end
  end

  task automatic cyc(input logic [NSRC-1:0] r, input bit b, input bit a, input bit rt);
    irq_req = r; at_boundary = b; int_ack = a; int_ret = rt;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc('0, 0, 0, 0); cyc('0, 0, 0, 0);
    check(cur_level == 0 && !int_out && !vec_valid && !stack_err,
          "R1 reset state", {cur_level, int_out, vec_valid, stack_err}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSRC; i++) src_level[i*3 +: 3] = 3'(LV[i]);
    #1;
    do_reset();
    cyc('0, 0, 0, 0);
    // R5: one-cycle pulse from source 1 (level 4), held off by boundary (R2)
    cyc(8'h02, 0, 0, 0);
    cyc('0, 0, 0, 0);
    check(!int_out, "R2 no offer off boundary", int_out, 0);
    cyc('0, 1, 0, 0);
    check(int_out, "R5 pulse latched", int_out, 1);
    cyc('0, 1, 1, 0);
    check(cur_level == 4 && vec_valid && vec_id == 1, "R4 accept level 4", cur_level, 4);
    // preemption by source 0 (level 7); source 2 (level 4) stays pending
    cyc(8'h05, 1, 0, 0);
    cyc('0, 1, 1, 0);
    check(cur_level == 7 && vec_id == 0, "R4 nested accept level 7", cur_level, 7);
    cyc('0, 1, 1, 0);
    check(!vec_valid && cur_level == 7, "R12 stray ack", cur_level, 7);
    cyc('0, 1, 0, 1);
    check(cur_level == 4, "R7 return to 4", cur_level, 4);
    check(!int_out, "R2 equal level waits", int_out, 0);
    cyc('0, 1, 0, 1);
    check(cur_level == 0, "R7 return to 0", cur_level, 0);
    check(int_out, "R6 other request kept", int_out, 1);
    cyc('0, 1, 1, 0);
    check(vec_id == 2 && cur_level == 4, "R6 source 2 served", vec_id, 2);
    // R11: ack and return together
    cyc(8'h01, 1, 0, 0);
    cyc('0, 1, 1, 1);
    check(cur_level == 0 && !vec_valid, "R11 return wins", cur_level, 0);
    cyc('0, 1, 1, 0);
    cyc('0, 1, 0, 1);
    // R3: tie at level 4, and highest among 1, 2, 5
    cyc(8'h06, 1, 0, 0);
    cyc('0, 1, 1, 0);
    check(vec_id == 1, "R3 tie lowest index", vec_id, 1);
    cyc('0, 1, 0, 1);
    cyc('0, 1, 1, 0);
    cyc('0, 1, 0, 1);
    cyc(8'h98, 1, 0, 0);
    cyc('0, 1, 1, 0);
    check(vec_id == 7 && cur_level == 5, "R3 highest level wins", vec_id, 7);
    cyc('0, 1, 0, 1);
    cyc('0, 1, 1, 0); cyc('0, 1, 0, 1);
    cyc('0, 1, 1, 0); cyc('0, 1, 0, 1);
    check(!int_out, "R2 level 0 source never offered", int_out, 0);
    // R8/R10 underflow
    cyc('0, 0, 0, 1);
    check(stack_err && cur_level == 0, "R8 underflow", stack_err, 1);
    cyc('0, 0, 0, 0); cyc('0, 0, 0, 0);
    check(stack_err, "R10 sticky", stack_err, 1);
    do_reset();
    // R9 overflow with DEPTH 3
    cyc(8'h10, 1, 0, 0); cyc('0, 1, 1, 0);
    cyc(8'h08, 1, 0, 0); cyc('0, 1, 1, 0);
    cyc(8'h20, 1, 0, 0); cyc('0, 1, 1, 0);
    check(cur_level == 3 && !stack_err, "R4 three deep", cur_level, 3);
    cyc(8'h02, 1, 0, 0); cyc('0, 1, 1, 0);
    check(stack_err && cur_level == 3 && !vec_valid, "R9 full refused", cur_level, 3);
    check(int_out, "R9 request kept", int_out, 1);
    do_reset();
    // mixed traffic against the reference
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom_range(0, 3) == 0) ? NSRC'($urandom) : '0,
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 4) == 0);
      if (n % 700 == 699) do_reset();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule